// File: doc/BRIEF.md
# Configuration Output Selector with Held Side Bit

This block picks where a small set of board configuration lines gets its value. There are three possible sources: stored configuration word 0, stored configuration word 1, and five external strap inputs. The block drives five configuration outputs from the chosen source. It also drives one side output, which is bit 5 of a stored word. Two select pins normally make the choice. A command code delivered by a neighbouring bus interface can take over from the pins and force a source, and a later command can hand control back to the pins.

The side output has its own path. When a stored word drives the outputs, the side bit is transparent and follows that word. When the strap inputs drive the outputs, select pin 0 makes the side bit transparent while it is low. While select pin 0 is high, the side bit holds the value it captured on the clock edge where that pin rose. All outputs carry the level to be seen on an open-drain line: 0 means the pull-down is on and 1 means the line is released.

The control core is a four-state machine. `PIN_CTRL` is the state after reset. `FORCE_W0`, `FORCE_W1` and `FORCE_STRAP` are the forced states. Prefix commands move between the states: from any state, `0xF8` goes to `FORCE_W0`, `0xFC` goes to `FORCE_W1`, a code `11111x10` goes to `FORCE_STRAP`, and a code `11111xx1` goes back to `PIN_CTRL`. Any other code leaves the state where it is.

Top module: `cfgsel_top`

## Requirements
- R1: Asynchronous active-low reset puts the machine in `PIN_CTRL`, clears the side-bit capture register and marks select pin 0 as previously low. While reset is held and after it is released, the outputs follow the select pins.
- R2: In `PIN_CTRL` with sel1=0 and sel0=1, cfg_out equals word 0 bits [4:0] and aux_out equals word 0 bit 5, in the same cycle.
- R3: In `PIN_CTRL` with sel1=0 and sel0=0, cfg_out equals word 1 bits [4:0] and aux_out equals word 1 bit 5, in the same cycle.
- R4: In `PIN_CTRL` with sel1=1, cfg_out equals the strap inputs in the same cycle, whatever sel0 is.
- R5: While the strap inputs drive cfg_out, there are three cases for aux_out. With sel0=0 it equals word 1 bit 5. In the cycle where sel0 is first seen high, it equals word 0 bit 5. On that clock edge, word 0 bit 5 is captured, and aux_out then holds the captured value, whatever the words do, until sel0 falls.
- R6: A valid command 0xF8 selects `FORCE_W0`. From the next cycle, cfg_out and aux_out come from word 0, and the select pins have no effect.
- R7: A valid command 0xFC selects `FORCE_W1`. From the next cycle, cfg_out and aux_out come from word 1.
- R8: A valid command matching 11111x10 selects `FORCE_STRAP`. From the next cycle, cfg_out follows the strap inputs, and aux_out follows the rule of R5.
- R9: A valid command matching 11111xx1 returns to `PIN_CTRL` from the next cycle.
- R10: A valid command whose top five bits are not all 1 does not change the state. A command with cmd_valid_i low does not change the state either.
- R11: With word 1 all zero, sel1 alone switches between word 0 (sel1=0, sel0=1) and the strap inputs (sel1=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel0_i | input | 1 | Select pin 0: chooses between the two words, and controls whether the side bit is transparent or held |
| sel1_i | input | 1 | Select pin 1: 1 chooses the strap inputs |
| strap_i | input | W (5) | External strap inputs |
| word0_i | input | W+1 (6) | Stored configuration word 0; the top bit is the side bit |
| word1_i | input | W+1 (6) | Stored configuration word 1; the top bit is the side bit |
| cmd_valid_i | input | 1 | One-cycle strobe that marks a command from the bus interface |
| cmd_code_i | input | 8 | Command code |
| cfg_out_o | output | W (5) | Configuration outputs; 0 turns the pull-down on |
| aux_out_o | output | 1 | Side output; 0 turns the pull-down on |

## Verification
The assertions assume three things about the inputs. Select pins and strap inputs are already synchronous to clk. Commands arrive as single-cycle strobes. The stored words change only between clock edges. The stimulus changes every input only just after a falling clock edge and pulses cmd_valid_i for one cycle at a time. It also starts the pins at their pulled-up level of all ones and moves the words while a capture is held, which exercises the held-value check of R5.

// File: rtl/cfgsel_pkg.sv
package cfgsel_pkg;

    localparam int          CMD_W      = 8;
    localparam int          PREFIX_W   = 5;
    localparam logic [PREFIX_W-1:0] CMD_PREFIX = '1;

    typedef enum logic [1:0] {
        PIN_CTRL    = 2'd0,
        FORCE_W0    = 2'd1,
        FORCE_W1    = 2'd2,
        FORCE_STRAP = 2'd3
    } ctl_state_e;

    typedef enum logic [1:0] {
        SRC_W0    = 2'd0,
        SRC_W1    = 2'd1,
        SRC_STRAP = 2'd2
    } src_e;

    // Next control state for one command; unknown prefixes keep the state.
    function automatic ctl_state_e cmd_next(input ctl_state_e cur,
                                            input logic [CMD_W-1:0] code);
        ctl_state_e nxt;
        nxt = cur;
        if (code[CMD_W-1 -: PREFIX_W] == CMD_PREFIX) begin
            if (code[0])      nxt = PIN_CTRL;
            else if (code[1]) nxt = FORCE_STRAP;
            else if (code[2]) nxt = FORCE_W1;
            else              nxt = FORCE_W0;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/cfgsel_ctl_fsm.sv
module cfgsel_ctl_fsm
    import cfgsel_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid_i,
    input  logic [CMD_W-1:0] cmd_code_i,
    input  logic             sel0_i,
    input  logic             sel1_i,
    output ctl_state_e       state_o,
    output src_e             src_o
);

    ctl_state_e state_q;
    ctl_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (cmd_valid_i) state_d = cmd_next(state_q, cmd_code_i);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PIN_CTRL;
        else        state_q <= state_d;
    end

    // Output decode: which source drives the lines
    always_comb begin
        unique case (state_q)
            PIN_CTRL:    src_o = sel1_i ? SRC_STRAP : (sel0_i ? SRC_W0 : SRC_W1);
            FORCE_W0:    src_o = SRC_W0;
            FORCE_W1:    src_o = SRC_W1;
            FORCE_STRAP: src_o = SRC_STRAP;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/cfgsel_side_hold.sv
module cfgsel_side_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic sel0_i,
    input  logic cap_bit_i,
    output logic held_o,
    output logic cap_q_o
);

    logic sel0_q;
    logic cap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel0_q <= 1'b0;
            cap_q  <= 1'b0;
        end else begin
            sel0_q <= sel0_i;
            if (sel0_i && !sel0_q) cap_q <= cap_bit_i;
        end
    end

    // Held once sel0 has been high across at least one edge
    assign held_o  = sel0_i && sel0_q;
    assign cap_q_o = cap_q;

endmodule

// File: rtl/cfgsel_route.sv
module cfgsel_route
    import cfgsel_pkg::*;
#(
    parameter int W = 5
) (
    input  src_e         src_i,
    input  logic [W-1:0] strap_i,
    input  logic [W:0]   word0_i,
    input  logic [W:0]   word1_i,
    input  logic         sel0_i,
    input  logic         held_i,
    input  logic         cap_q_i,
    output logic [W-1:0] cfg_o,
    output logic         aux_o
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_comb begin
            case (src_i)
                SRC_W0:    cfg_o[b] = word0_i[b];
                SRC_W1:    cfg_o[b] = word1_i[b];
                SRC_STRAP: cfg_o[b] = strap_i[b];
                default:   cfg_o[b] = 1'b1;
            endcase
        end
    end

    always_comb begin
        case (src_i)
            SRC_W0:    aux_o = word0_i[W];
            SRC_W1:    aux_o = word1_i[W];
            SRC_STRAP: aux_o = held_i ? cap_q_i : (sel0_i ? word0_i[W] : word1_i[W]);
            default:   aux_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/cfgsel_top.sv
module cfgsel_top
    import cfgsel_pkg::*;
#(
    parameter int W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel0_i,
    input  logic             sel1_i,
    input  logic [W-1:0]     strap_i,
    input  logic [W:0]       word0_i,
    input  logic [W:0]       word1_i,
    input  logic             cmd_valid_i,
    input  logic [CMD_W-1:0] cmd_code_i,
    output logic [W-1:0]     cfg_out_o,
    output logic             aux_out_o
);

    ctl_state_e state_w;
    src_e       src_w;
    logic       held_w;
    logic       cap_w;

    cfgsel_ctl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid_i (cmd_valid_i),
        .cmd_code_i  (cmd_code_i),
        .sel0_i      (sel0_i),
        .sel1_i      (sel1_i),
        .state_o     (state_w),
        .src_o       (src_w)
    );

    cfgsel_side_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel0_i    (sel0_i),
        .cap_bit_i (word0_i[W]),
        .held_o    (held_w),
        .cap_q_o   (cap_w)
    );

    cfgsel_route #(.W(W)) u_route (
        .src_i   (src_w),
        .strap_i (strap_i),
        .word0_i (word0_i),
        .word1_i (word1_i),
        .sel0_i  (sel0_i),
        .held_i  (held_w),
        .cap_q_i (cap_w),
        .cfg_o   (cfg_out_o),
        .aux_o   (aux_out_o)
    );

endmodule

// File: rtl/cfgsel_chk.sv
module cfgsel_chk
    import cfgsel_pkg::*;
#(
    parameter int W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel0_i,
    input logic             sel1_i,
    input logic [W-1:0]     strap_i,
    input logic [W:0]       word0_i,
    input logic [W:0]       word1_i,
    input logic             cmd_valid_i,
    input logic [CMD_W-1:0] cmd_code_i,
    input logic [W-1:0]     cfg_out_o,
    input logic             aux_out_o,
    input ctl_state_e       state,
    input src_e             src
);

    logic since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) since_rst <= 1'b0;
        else        since_rst <= 1'b1;
    end

    logic pfx;
    assign pfx = (cmd_code_i[CMD_W-1 -: 5] == 5'b11111);

    // R2
    pin_w0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PIN_CTRL && !sel1_i && sel0_i) |-> (cfg_out_o == word0_i[W-1:0] && aux_out_o == word0_i[W]));

    // R4
    pin_strap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PIN_CTRL && sel1_i) |-> (cfg_out_o == strap_i));

    // R5
    side_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst && src == SRC_STRAP && $past(src) == SRC_STRAP && sel0_i && $past(sel0_i)) |-> $stable(aux_out_o));

    // R6
    force_w0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_code_i == 8'hF8) |=> (cfg_out_o == word0_i[W-1:0] && aux_out_o == word0_i[W]));

    // R7
    force_w1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_code_i == 8'hFC) |=> (cfg_out_o == word1_i[W-1:0] && aux_out_o == word1_i[W]));

    // R8
    force_strap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && pfx && cmd_code_i[1:0] == 2'b10) |=> (cfg_out_o == strap_i));

    // R9
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && pfx && cmd_code_i[0]) |=> (state == PIN_CTRL));

    // R10
    ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid_i || !pfx) |=> $stable(state));

endmodule

bind cfgsel_top cfgsel_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel0_i      (sel0_i),
    .sel1_i      (sel1_i),
    .strap_i     (strap_i),
    .word0_i     (word0_i),
    .word1_i     (word1_i),
    .cmd_valid_i (cmd_valid_i),
    .cmd_code_i  (cmd_code_i),
    .cfg_out_o   (cfg_out_o),
    .aux_out_o   (aux_out_o),
    .state       (state_w),
    .src         (src_w)
);

// File: tb/tb_cfgsel_top.sv
`timescale 1ns/1ps
module tb_cfgsel_top;

    localparam int W = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sel0 = 1'b1;
    logic         sel1 = 1'b1;
    logic [W-1:0] strap = '1;
    logic [W:0]   word0 = '0;
    logic [W:0]   word1 = '0;
    logic         cmd_valid = 1'b0;
    logic [7:0]   cmd_code = 8'h00;
    logic [W-1:0] cfg_out;
    logic         aux_out;

    int    vectors = 0;
    int    errors = 0;
    string tag = "R1";

    // reference model: 0 pins, 1 word0, 2 word1, 3 strap
    int m_mode = 0;
    bit m_prev0 = 0;
    bit m_cap = 0;

    always #4 clk = ~clk;

    cfgsel_top #(.W(W)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel0_i      (sel0),
        .sel1_i      (sel1),
        .strap_i     (strap),
        .word0_i     (word0),
        .word1_i     (word1),
        .cmd_valid_i (cmd_valid),
        .cmd_code_i  (cmd_code),
        .cfg_out_o   (cfg_out),
        .aux_out_o   (aux_out)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode  <= 0;
            m_prev0 <= 0;
            m_cap   <= 0;
        end else begin
            if (cmd_valid && cmd_code >= 8'hF8) begin
                if (cmd_code % 2 == 1)           m_mode <= 0;
                else if ((cmd_code / 2) % 2 == 1) m_mode <= 3;
                else if (cmd_code == 8'hFC)      m_mode <= 2;
                else                             m_mode <= 1;
            end
            if (sel0 && !m_prev0) m_cap <= word0[W];
            m_prev0 <= sel0;
        end
    end

    task automatic check_now();
        int src;
        logic [W-1:0] e_cfg;
        logic e_aux;
        if (m_mode == 0) src = sel1 ? 3 : (sel0 ? 1 : 2);
        else             src = m_mode;
        if (src == 1)      begin e_cfg = word0[W-1:0]; e_aux = word0[W]; end
        else if (src == 2) begin e_cfg = word1[W-1:0]; e_aux = word1[W]; end
        else begin
            e_cfg = strap;
            if (sel0 && m_prev0) e_aux = m_cap;
            else                 e_aux = sel0 ? word0[W] : word1[W];
        end
        vectors++;
        if (cfg_out !== e_cfg || aux_out !== e_aux) begin
            errors++;
            $display("FAIL %s: cfg_out=%b aux_out=%b expected cfg_out=%b aux_out=%b",
                     tag, cfg_out, aux_out, e_cfg, e_aux);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_now();
        end
    endtask

    task automatic send(input logic [7:0] code);
        cmd_valid = 1'b1;
        cmd_code  = code;
        step(1);
        cmd_valid = 1'b0;
        cmd_code  = 8'h00;
    endtask

    initial begin
        #1600000;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        word0 = 6'b10_1010;
        word1 = 6'b01_0101;
        strap = 5'b11001;
        // R1: outputs follow the pins while in reset and after it
        sel1 = 1'b0; sel0 = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(2);

        tag = "R2"; sel0 = 1'b1; step(2);
        word0 = 6'b01_1100; step(1);
        tag = "R3"; sel0 = 1'b0; step(2);
        word1 = 6'b10_0011; step(1);
        tag = "R4"; sel1 = 1'b1; step(1);
        strap = 5'b00110; step(1);
        sel0 = 1'b1; step(1);
        strap = 5'b10101; step(1);

        // R5: capture on sel0 rise, hold while high
        tag = "R5";
        sel0 = 1'b0; word0 = 6'b10_0000; word1 = 6'b00_0000; step(2);
        sel0 = 1'b1; step(1);
        word0 = 6'b00_1111; step(2);
        word1 = 6'b11_1111; step(2);
        sel0 = 1'b0; step(2);
        sel0 = 1'b1; step(3);

        tag = "R6"; send(8'hF8); sel1 = 1'b1; sel0 = 1'b0; step(2);
        word0 = 6'b11_0110; step(1);
        tag = "R10"; send(8'h00); send(8'h7F); send(8'hE8); step(2);
        cmd_code = 8'hFC; step(2); cmd_code = 8'h00;
        tag = "R7"; send(8'hFC); sel1 = 1'b0; sel0 = 1'b1; step(2);
        tag = "R8"; send(8'hFA); step(2); send(8'hFC); send(8'hFE); strap = 5'b01110; step(2);
        tag = "R9"; send(8'hF9); sel1 = 1'b0; sel0 = 1'b1; step(2);
        send(8'hF8); send(8'hFF); sel0 = 1'b0; step(2);
        send(8'hFE); send(8'hFB); step(1);
        send(8'hF8); send(8'hFD); sel1 = 1'b1; step(2);

        tag = "R11"; word1 = '0; sel0 = 1'b1;
        sel1 = 1'b0; step(2); sel1 = 1'b1; step(2); sel1 = 1'b0; step(2);

        tag = "R1"; rst_n = 1'b0; step(2); rst_n = 1'b1; sel1 = 1'b0; sel0 = 1'b0; step(2);

        tag = "MIX";
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] r;
            r = $urandom;
            sel0  = r[0] | r[1];
            sel1  = r[2];
            strap = r[7:3];
            if (r[8]) word0 = r[14:9];
            if (r[15]) word1 = r[21:16];
            cmd_valid = (r[24:22] == 3'b000);
            cmd_code  = r[25] ? {5'b11111, r[28:26]} : r[31:24];
            step(1);
        end
        cmd_valid = 1'b0;
        step(1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule